// File: doc/BRIEF.md
# Clockless-Wake Edge Interrupt Port

This block watches eight input pins and raises an interrupt when one of them makes a chosen transition. Each pin has a bit that selects whether its rising or its falling edge counts, a bit that enables it, and a pending flag. The pending flag is set by the pin's transition itself rather than by a sampling clock. Because of this, a transition is caught even when the system clock has been fully stopped for the deepest sleep state.

The OR of all enabled pending flags leaves the block at once as a wake request. This signal is meant to start the internal oscillator that then becomes the system clock. Once the clock runs, the flags pass through a two-stage synchronizer into the clock domain and form the interrupt request to the processor. Software reads and clears the flags through a small register port with write strobe, address and data. That port has no back-pressure: a write takes effect on the clock edge where the strobe is high, and read data is a combinational function of the address.

Top module: `pinwake_port`

## Requirements
- R1: With a pin's select bit at 0, a low-to-high transition on that pin sets its pending flag.
- R2: With a pin's select bit at 1, a high-to-low transition sets the pending flag, and a low-to-high transition does not.
- R3: A selected transition sets its flag and raises `wake_o` while `clk` is not toggling.
- R4: A pulse much shorter than one clock period is still captured.
- R5: `wake_o` is the OR of pending flags whose enable bit is 1. A pending flag whose enable bit is 0 does not raise `wake_o` or `irq_o`.
- R6: `irq_o` is the OR of the enabled flags as seen through two clock stages. A flag set between two rising edges reaches `irq_o` after the second of those edges that follow.
- R7: Writing address 2 clears each pending flag whose data bit is 1 on that clock edge. Data bits at 0 leave their flags unchanged.
- R8: If a selected transition on a pin occurs during the clock period that ends with a clear of that pin's flag, the flag stays set.
- R9: Changing a pin's select bit so that its effective level goes from low to high sets that pin's flag.
- R10: `wake_o` stays high until every enabled pending flag has been cleared or disabled.
- R11: After reset, all flags, enables and select bits are 0, and `wake_o` and `irq_o` are low.
- R12: The register map is as follows. Address 0 holds the select bits (1 = falling edge). Address 1 holds the enable bits. Address 2 reads the synchronized pending flags and clears them on a write. Address 3 reads 0. Bit i always refers to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Pin levels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| wake_o | output | 1 | Unsynchronized wake request to the clock generator |
| irq_o | output | 1 | Synchronized interrupt request to the processor |

## Verification
The hardest cases to reach are the ones where the clock gives no help. The first is capture while `clk` is frozen. The bench gates its own clock generator, pulses a pin while no edges occur, and checks `wake_o` before it lets the clock run again. The second is an edge that lands inside the clear cycle. The bench re-arms a pin in the period just before it writes the clear and expects the flag to survive. For sub-period pulses, the bench drives a 2 ns pulse between clock edges. A behavioural model follows every asynchronous transition and compares all outputs on each falling clock edge.

// File: rtl/pinwake_pkg.sv
package pinwake_pkg;
  typedef enum logic [1:0] {
    RG_EDGE = 2'd0,
    RG_MASK = 2'd1,
    RG_PEND = 2'd2,
    RG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_capture.sv
module pin_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_i,
  input  logic clr_i,
  output logic flag_o
);
  logic trig;
  logic set_tok, evt_tog;
  logic ack_tok, evt_seen;
  logic evt_new;

  assign trig = pin_i ^ fall_i;

  // Clockless side: the qualified edge is the clock of these flops
  always_ff @(posedge trig or negedge rst_n) begin
    if (!rst_n) begin
      set_tok <= 1'b0;
      evt_tog <= 1'b0;
    end else begin
      set_tok <= ~ack_tok;
      evt_tog <= ~evt_tog;
    end
  end

  assign evt_new = (evt_tog != evt_seen);

  // Clocked side: acknowledge on clear unless an edge arrived this period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tok  <= 1'b0;
      evt_seen <= 1'b0;
    end else begin
      evt_seen <= evt_tog;
      if (clr_i && !evt_new) ack_tok <= set_tok;
    end
  end

  assign flag_o = set_tok ^ ack_tok;

  assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_new) |=> flag_o);
endmodule

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
  import pinwake_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] pend_sync_i,
  output logic [NPINS-1:0] rdata_o,
  output logic [NPINS-1:0] fall_o,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] clr_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_o <= '0;
      en_o   <= '0;
    end else if (we_i) begin
      if (sel == RG_EDGE) fall_o <= wdata_i;
      if (sel == RG_MASK) en_o   <= wdata_i;
    end
  end

  assign clr_o = (we_i && sel == RG_PEND) ? wdata_i : '0;

  always_comb begin
    unique case (sel)
      RG_EDGE: rdata_o = fall_o;
      RG_MASK: rdata_o = en_o;
      RG_PEND: rdata_o = pend_sync_i;
      default: rdata_o = '0;
    endcase
  end

  assert_reset_state_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> (fall_o == '0 && en_o == '0));
endmodule

// File: rtl/pinwake_port.sv
module pinwake_port
  import pinwake_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [NPINS-1:0] cfg_wdata,
  output logic [NPINS-1:0] cfg_rdata,
  output logic             wake_o,
  output logic             irq_o
);
  localparam int SYNC_STAGES = 2;

  logic [NPINS-1:0] fall_q, en_q, clr, flag, flag_s;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_capture u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i[i]),
      .fall_i (fall_q[i]),
      .clr_i  (clr[i]),
      .flag_o (flag[i])
    );
  end

  flag_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flag),
    .q_o   (flag_s)
  );

  port_regs #(.NPINS(NPINS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (cfg_we),
    .addr_i      (cfg_addr),
    .wdata_i     (cfg_wdata),
    .pend_sync_i (flag_s),
    .rdata_o     (cfg_rdata),
    .fall_o      (fall_q),
    .en_o        (en_q),
    .clr_o       (clr)
  );

  assign wake_o = |(flag & en_q);
  assign irq_o  = |(flag_s & en_q);

  assert_wake_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !(cfg_we && (cfg_addr == RG_MASK || cfg_addr == RG_PEND))) |=> wake_o);

  assert_irq_follows_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && $stable(en_q)) |-> $past(wake_o));
endmodule

// File: tb/test_pinwake_port.sv
module test_pinwake_port;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       wake_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] m_flag = '0, m_s1 = '0, m_s2 = '0, m_sel = '0, m_en = '0, m_trig = '0, m_evt = '0;

  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  pinwake_port i_pinwake_port (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wake_o(wake_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply_trig();
    logic [7:0] t;
    t = pins ^ m_sel;
    for (int i = 0; i < 8; i++)
      if (t[i] && !m_trig[i]) begin m_flag[i] = 1'b1; m_evt[i] = 1'b1; end
    m_trig = t;
  endtask

  task automatic compare(input string tag);
    logic [7:0] rd;
    case (cfg_addr)
      2'd0: rd = m_sel;
      2'd1: rd = m_en;
      2'd2: rd = m_s2;
      default: rd = '0;
    endcase
    check(tag, "wake_o", {7'd0, wake_o}, {7'd0, |(m_flag & m_en)});
    check(tag, "irq_o", {7'd0, irq_o}, {7'd0, |(m_s2 & m_en)});
    check(tag, "cfg_rdata", cfg_rdata, rd);
  endtask

  // one clock cycle: cfg applied at the rising edge, pins move 2 ns later
  task automatic step(input logic [7:0] p_new, input logic [7:0] pulse, input logic we,
                      input logic [1:0] a, input logic [7:0] d, input string tag);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    m_s2 = m_s1; m_s1 = m_flag;
    if (we) begin
      case (a)
        2'd0: m_sel = d;
        2'd1: m_en = d;
        2'd2: for (int i = 0; i < 8; i++) if (d[i] && !m_evt[i]) m_flag[i] = 1'b0;
        default: ;
      endcase
    end
    m_evt = '0;
    apply_trig();
    #2;
    pins = p_new ^ pulse; apply_trig();
    if (pulse != 0) begin #2; pins = p_new; apply_trig(); end
    @(negedge clk);
    cfg_we = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input int n, input logic [1:0] a, input string tag);
    for (int k = 0; k < n; k++) step(pins, 8'h00, 1'b0, a, 8'h00, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "wake_o in reset", {7'd0, wake_o}, 8'h00);
    check("R11", "irq_o in reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    idle(1, 2'd0, "R11 sel reset");
    idle(1, 2'd1, "R11 en reset");
    idle(1, 2'd2, "R11 pend reset");
    idle(1, 2'd3, "R12 addr3 zero");

    // enable all, rising edge on pin0
    step(8'h00, 8'h00, 1'b1, 2'd1, 8'hFF, "R12 en write");
    step(8'h01, 8'h00, 1'b0, 2'd2, 8'h00, "R1 rising pin0");
    idle(3, 2'd2, "R6 irq after sync");
    // write 0 does nothing, write 1 clears
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h00, "R7 write zero keeps");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h01, "R7 clear pin0");
    idle(3, 2'd2, "R7 after clear");

    // select change sets flag: pin2 low, select falling
    step(8'h01, 8'h00, 1'b1, 2'd0, 8'h04, "R9 select change");
    idle(2, 2'd0, "R9 after select");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h04, "R9 clear");
    // pin1 falling mode: select sets it, clear, then rise ignored, fall sets
    step(8'h01, 8'h00, 1'b1, 2'd0, 8'h06, "R2 select pin1");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h02, "R2 clear");
    idle(2, 2'd2, "R2 settle");
    step(8'h03, 8'h00, 1'b0, 2'd2, 8'h00, "R2 rise ignored");
    idle(3, 2'd2, "R2 rise ignored idle");
    step(8'h01, 8'h00, 1'b0, 2'd2, 8'h00, "R2 fall sets");
    idle(3, 2'd2, "R2 fall idle");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h02, "R2 clear after");

    // short pulse on pin3 (rising)
    step(8'h01, 8'h08, 1'b0, 2'd2, 8'h00, "R4 short pulse");
    idle(3, 2'd2, "R4 pulse sync");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h08, "R4 clear");

    // pin4 masked: pending but no wake
    step(8'h01, 8'h00, 1'b1, 2'd1, 8'hEF, "R5 mask pin4");
    step(8'h01, 8'h10, 1'b0, 2'd2, 8'h00, "R5 masked pulse");
    idle(3, 2'd2, "R5 masked pending visible");
    step(8'h01, 8'h00, 1'b1, 2'd1, 8'hFF, "R5 unmask wakes");
    idle(2, 2'd2, "R5 unmasked irq");

    // two pending (pin4, pin5): clear one, wake stays
    step(8'h01, 8'h20, 1'b0, 2'd2, 8'h00, "R10 second pending");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h10, "R10 clear one");
    idle(2, 2'd2, "R10 wake held");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h20, "R10 clear last");
    idle(3, 2'd2, "R10 wake dropped");

    // edge in the same period as the clear: pin0 low, rise, then clear
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h01, "R7 clear pin0 again");
    step(8'h00, 8'h00, 1'b0, 2'd2, 8'h00, "R8 pin0 low");
    step(8'h00, 8'h00, 1'b1, 2'd2, 8'h01, "R8 clear idle flag");
    step(8'h01, 8'h00, 1'b0, 2'd2, 8'h00, "R8 rearm");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h01, "R8 clear loses");
    idle(3, 2'd2, "R8 flag survives");
    step(8'h01, 8'h00, 1'b1, 2'd2, 8'h01, "R8 final clear");
    idle(3, 2'd2, "R8 cleared");

    // clock stopped: pulse pin6, wake must rise without edges
    clk_run = 1'b0;
    #55;
    check("R3", "wake_o before", {7'd0, wake_o}, 8'h00);
    pins = pins ^ 8'h40; apply_trig();
    #1;
    pins = pins ^ 8'h40; apply_trig();
    #5;
    check("R3", "wake_o while clock stopped", {7'd0, wake_o}, 8'h01);
    check("R3", "irq_o while clock stopped", {7'd0, irq_o}, 8'h00);
    clk_run = 1'b1;
    idle(3, 2'd2, "R3 restarted irq");
    step(pins, 8'h00, 1'b1, 2'd2, 8'h40, "R3 clear");
    idle(3, 2'd2, "R3 quiet");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule